// File: doc/BRIEF.md
# Multi-Symbol Regressor Window Buffer

This block sits between two cascaded adaptive filter stages of a multiuser receiver. The first stage produces one real-valued soft output per user per symbol period. The buffer collects those outputs into a small circular store of symbol slots. For each centre symbol n it presents the second stage with a regressor of 3K elements: the outputs of every user at symbol n-1, at symbol n and at symbol n+1. The second stage reads the regressor one element at a time by index. It releases the window when it has finished with it, and the centre then moves forward by one symbol.

Soft outputs enter on a valid/ready stream, one user per beat, users in order 0..K-1 within a symbol. When accepting the next value would overwrite a slot that the current window still needs, `wr_ready` drops. The producer must hold `wr_valid` and `wr_data` until a beat with `wr_ready` high. The window is ready only once the whole of symbol n+1 is stored, or once the frame has been closed. Previous-symbol elements read as zero for the first window of a frame. Next-symbol elements read as zero for the last window of a frame. A flush restarts the frame.

The block also slices the second stage's output to a hard decision bit. This path is a one-entry registered stage with valid/ready on both sides. A held output stays stable while `bit_ready` is low, and the input is accepted whenever the output register is empty or is being drained in the same cycle. `SLOTS` must be at least 4.

Top module: `regressor_window_buf`

## Requirements
- R1: The regressor has exactly 3*NUM_USERS elements. Any `rd_idx` of 3*NUM_USERS or more reads as zero.
- R2: Element `rd_idx` = g*NUM_USERS + u returns user u's stored output at symbol n-1+g for g in {0,1,2}, where n is the current centre.
- R3: `win_valid` stays low until every user's output for symbol n+1 has been accepted (or R5 applies). It rises in the cycle after the last such write.
- R4: For the first window after reset or flush (centre symbol 0), elements 0..NUM_USERS-1 read as zero.
- R5: A `frame_end` pulse closes the frame. `wr_ready` is then low until flush, and the last stored symbol gets a valid window whose elements 2*NUM_USERS..3*NUM_USERS-1 read as zero.
- R6: While the frame is open, `wr_ready` is low exactly when the centre symbol and the two symbols after it are all completely stored. Otherwise it is high.
- R7: A `win_done` pulse while `win_valid` is high advances the centre by one symbol. While `win_valid` is low, `win_done` has no effect.
- R8: A `flush` pulse clears all slots and the window state. In the next cycle `win_valid` is low, `wr_ready` is high and writes start again at symbol 0, user 0.
- R9: An accepted `det_data` (signed) produces `bit_pos` = 1 when it is zero or positive and `bit_pos` = 0 when it is negative, with `bit_valid` high in the next cycle.
- R10: `det_ready` is high exactly when `bit_valid` is low or `bit_ready` is high. While `bit_valid` is high and `bit_ready` is low, `bit_valid` and `bit_pos` hold.
- R11: After reset `win_valid` and `bit_valid` are low, and `wr_ready` and `det_ready` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Frame restart pulse |
| frame_end | input | 1 | Frame close pulse, given at a symbol boundary |
| wr_valid | input | 1 | Soft output beat valid |
| wr_ready | output | 1 | Soft output beat accepted |
| wr_data | input | DATA_W | Signed soft output of the next user in order |
| win_valid | output | 1 | Regressor for the current centre is complete |
| win_done | input | 1 | Consumer releases the current window |
| rd_idx | input | IDX_W | Regressor element index |
| rd_data | output | DATA_W | Signed regressor element (combinational) |
| det_valid | input | 1 | Second-stage output valid |
| det_ready | output | 1 | Second-stage output accepted |
| det_data | input | OUT_W | Signed second-stage output |
| bit_valid | output | 1 | Hard decision valid |
| bit_ready | input | 1 | Hard decision consumed |
| bit_pos | output | 1 | Decision: 1 means +1, 0 means -1 |

## Verification
The bench builds the block with three users, four slots, 12-bit soft values and 10-bit second-stage values. Three users makes the index split a non-power-of-two division, and it leaves the 4-bit index space with out-of-range values (9..15) for R1. Four slots is the smallest legal ring, so the writer reaches the back-pressure point (R6) after only two symbols beyond the centre, and the ring pointers wrap several times within a ten-symbol frame. The narrow data widths put the signed extremes and exact zero within easy reach of directed stimulus.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

  localparam int GROUPS = 3;

  typedef enum logic [1:0] {
    GRP_PREV = 2'd0,
    GRP_CUR  = 2'd1,
    GRP_NEXT = 2'd2
  } grp_e;

  function automatic int wrap_slot(input int base, input int off, input int slots);
    return (base + off) % slots;
  endfunction

endpackage

// File: rtl/rwb_slot_store.sv
module rwb_slot_store #(
  parameter int K      = 4,
  parameter int SLOTS  = 4,
  parameter int DATA_W = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int USER_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [USER_W-1:0] wuser,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rslot,
  input  logic [USER_W-1:0] ruser,
  output logic [DATA_W-1:0] rdata
);

  logic [K-1:0][DATA_W-1:0] rows [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [K-1:0][DATA_W-1:0] row_q;

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        row_q <= '0;
      end else if (we && (wslot == SLOT_W'(s))) begin
        row_q[wuser] <= wdata;
      end
    end

    assign rows[s] = row_q;
  end

  assign rdata = rows[rslot][ruser];

endmodule

// File: rtl/rwb_window_ctrl.sv
module rwb_window_ctrl #(
  parameter int K     = 4,
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int AH_W   = $clog2(SLOTS),
  localparam int USER_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              frame_end,
  input  logic              wr_fire,
  input  logic              win_done,
  output logic              wr_ready,
  output logic              win_valid,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [USER_W-1:0] wr_user,
  output logic [SLOT_W-1:0] head,
  output logic              at_start,
  output logic              next_present
);

  import rwb_pkg::*;

  logic [USER_W-1:0] user_q;
  logic [AH_W-1:0]   ahead_q;
  logic [SLOT_W-1:0] head_q;
  logic              start_q;
  logic              ended_q;
  logic              sym_done;
  logic              advance;

  assign next_present = (ahead_q >= AH_W'(2));
  assign win_valid    = next_present || (ended_q && (ahead_q != '0));
  assign wr_ready     = !ended_q && (ahead_q <= AH_W'(SLOTS - 2));
  assign sym_done     = wr_fire && (user_q == USER_W'(K - 1));
  assign advance      = win_done && win_valid;

  assign wr_slot  = SLOT_W'(wrap_slot(int'(head_q), int'(ahead_q), SLOTS));
  assign wr_user  = user_q;
  assign head     = head_q;
  assign at_start = start_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      user_q  <= '0;
      ahead_q <= '0;
      head_q  <= '0;
      start_q <= 1'b1;
      ended_q <= 1'b0;
    end else begin
      if (wr_fire) begin
        user_q <= sym_done ? '0 : user_q + 1'b1;
      end
      ahead_q <= ahead_q + AH_W'(sym_done) - AH_W'(advance);
      if (advance) begin
        head_q  <= SLOT_W'(wrap_slot(int'(head_q), 1, SLOTS));
        start_q <= 1'b0;
      end
      if (frame_end) begin
        ended_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rwb_index_map.sv
module rwb_index_map #(
  parameter int K     = 4,
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int USER_W = (K > 1) ? $clog2(K) : 1,
  localparam int IDX_W  = $clog2(3 * K + 1)
) (
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [SLOT_W-1:0] head,
  input  logic              at_start,
  input  logic              next_present,
  output logic [SLOT_W-1:0] rslot,
  output logic [USER_W-1:0] ruser,
  output logic              force_zero
);

  import rwb_pkg::*;

  int   idx_i;
  int   grp_i;
  int   usr_i;
  logic in_range;
  grp_e grp;

  always_comb begin
    idx_i    = int'(rd_idx);
    in_range = (idx_i < GROUPS * K);
    grp_i    = in_range ? (idx_i / K) : 0;
    usr_i    = in_range ? (idx_i % K) : 0;
    grp      = grp_e'(grp_i[1:0]);
    ruser    = USER_W'(usr_i);
    rslot    = SLOT_W'(wrap_slot(int'(head), grp_i + SLOTS - 1, SLOTS));
    force_zero = !in_range
               || ((grp == GRP_PREV) && at_start)
               || ((grp == GRP_NEXT) && !next_present);
  end

endmodule

// File: rtl/rwb_sign_slicer.sv
module rwb_sign_slicer #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_valid,
  output logic             det_ready,
  input  logic [OUT_W-1:0] det_data,
  output logic             bit_valid,
  input  logic             bit_ready,
  output logic             bit_pos
);

  assign det_ready = !bit_valid || bit_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_pos   <= 1'b0;
    end else if (det_ready) begin
      bit_valid <= det_valid;
      if (det_valid) begin
        bit_pos <= !det_data[OUT_W-1];
      end
    end
  end

endmodule

// File: rtl/regressor_window_buf.sv
module regressor_window_buf #(
  parameter int NUM_USERS = 4,
  parameter int SLOTS     = 4,
  parameter int DATA_W    = 16,
  parameter int OUT_W     = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int USER_W = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int IDX_W  = $clog2(3 * NUM_USERS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     frame_end,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic signed [DATA_W-1:0] wr_data,
  output logic                     win_valid,
  input  logic                     win_done,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [DATA_W-1:0] rd_data,
  input  logic                     det_valid,
  output logic                     det_ready,
  input  logic signed [OUT_W-1:0]  det_data,
  output logic                     bit_valid,
  input  logic                     bit_ready,
  output logic                     bit_pos
);

  logic              wr_fire;
  logic [SLOT_W-1:0] wr_slot;
  logic [USER_W-1:0] wr_user;
  logic [SLOT_W-1:0] head;
  logic              at_start;
  logic              next_present;
  logic [SLOT_W-1:0] rslot;
  logic [USER_W-1:0] ruser;
  logic              force_zero;
  logic [DATA_W-1:0] store_rdata;

  assign wr_fire = wr_valid && wr_ready;

  rwb_window_ctrl #(.K(NUM_USERS), .SLOTS(SLOTS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .frame_end    (frame_end),
    .wr_fire      (wr_fire),
    .win_done     (win_done),
    .wr_ready     (wr_ready),
    .win_valid    (win_valid),
    .wr_slot      (wr_slot),
    .wr_user      (wr_user),
    .head         (head),
    .at_start     (at_start),
    .next_present (next_present)
  );

  rwb_slot_store #(.K(NUM_USERS), .SLOTS(SLOTS), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .we    (wr_fire),
    .wslot (wr_slot),
    .wuser (wr_user),
    .wdata (wr_data),
    .rslot (rslot),
    .ruser (ruser),
    .rdata (store_rdata)
  );

  rwb_index_map #(.K(NUM_USERS), .SLOTS(SLOTS)) u_map (
    .rd_idx       (rd_idx),
    .head         (head),
    .at_start     (at_start),
    .next_present (next_present),
    .rslot        (rslot),
    .ruser        (ruser),
    .force_zero   (force_zero)
  );

  assign rd_data = force_zero ? '0 : $signed(store_rdata);

  rwb_sign_slicer #(.OUT_W(OUT_W)) u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .det_valid (det_valid),
    .det_ready (det_ready),
    .det_data  (det_data),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .bit_pos   (bit_pos)
  );

endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
  parameter int NUM_USERS = 4,
  parameter int DATA_W    = 16,
  parameter int OUT_W     = 16,
  localparam int IDX_W = $clog2(3 * NUM_USERS + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic                     frame_end,
  input logic                     wr_valid,
  input logic                     wr_ready,
  input logic                     win_valid,
  input logic                     win_done,
  input logic [IDX_W-1:0]         rd_idx,
  input logic signed [DATA_W-1:0] rd_data,
  input logic                     det_valid,
  input logic                     det_ready,
  input logic signed [OUT_W-1:0]  det_data,
  input logic                     bit_valid,
  input logic                     bit_ready,
  input logic                     bit_pos
);

  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IDX_W'(3 * NUM_USERS)) |-> (rd_data == '0));

  p_valid_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_valid) |-> ($past(wr_valid && wr_ready) || $past(frame_end)));

  p_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !flush) |=> !wr_ready);

  p_done_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !win_valid && !wr_valid && !frame_end) |=> !win_valid);

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!win_valid && wr_ready));

  p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_ready) |=> (bit_valid && (bit_pos == ($past(det_data) >= 0))));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_pos)));

endmodule

bind regressor_window_buf rwb_checker #(
  .NUM_USERS (NUM_USERS),
  .DATA_W    (DATA_W),
  .OUT_W     (OUT_W)
) i_rwb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .frame_end (frame_end),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .win_valid (win_valid),
  .win_done  (win_done),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .det_valid (det_valid),
  .det_ready (det_ready),
  .det_data  (det_data),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready),
  .bit_pos   (bit_pos)
);

// File: tb/test_regressor_window_buf.sv
module test_regressor_window_buf;

  localparam int CLK_PERIOD = 10;
  localparam int K  = 3;
  localparam int SL = 4;
  localparam int DW = 12;
  localparam int OW = 10;
  localparam int IW = $clog2(3 * K + 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 flush = 1'b0;
  logic                 frame_end = 1'b0;
  logic                 wr_valid = 1'b0;
  logic                 wr_ready;
  logic signed [DW-1:0] wr_data = '0;
  logic                 win_valid;
  logic                 win_done = 1'b0;
  logic [IW-1:0]        rd_idx = '0;
  logic signed [DW-1:0] rd_data;
  logic                 det_valid = 1'b0;
  logic                 det_ready;
  logic signed [OW-1:0] det_data = '0;
  logic                 bit_valid;
  logic                 bit_ready = 1'b0;
  logic                 bit_pos;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int sym_val [16][K];

  always #(CLK_PERIOD / 2) clk = ~clk;

  regressor_window_buf #(
    .NUM_USERS (K),
    .SLOTS     (SL),
    .DATA_W    (DW),
    .OUT_W     (OW)
  ) i_regressor_window_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .frame_end (frame_end),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .win_valid (win_valid),
    .win_done  (win_done),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .det_valid (det_valid),
    .det_ready (det_ready),
    .det_data  (det_data),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .bit_pos   (bit_pos)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rand_val(input int span);
    return int'($urandom % span) - span / 2;
  endfunction

  function automatic int expect_elem(input int n, input int idx, input bit last);
    int g = idx / K;
    int u = idx % K;
    if (idx >= 3 * K) return 0;
    if (g == 0) return (n == 0) ? 0 : sym_val[n-1][u];
    if (g == 1) return sym_val[n][u];
    return last ? 0 : sym_val[n+1][u];
  endfunction

  task automatic write_user(input int s, input int u);
    @(negedge clk);
    for (int w = 0; w < 40 && !wr_ready; w++) @(negedge clk);
    chk("R6 writer stalled", int'(wr_ready), 1);
    wr_valid = 1'b1;
    wr_data  = DW'(sym_val[s][u]);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic write_sym(input int s);
    for (int u = 0; u < K; u++) write_user(s, u);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    win_done = 1'b1;
    @(negedge clk);
    win_done = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  // R2 ordering, R4 start zeros, R5 end zeros
  task automatic check_window(input int n, input bit last);
    chk("R3 window valid", int'(win_valid), 1);
    for (int i = 0; i < 3 * K; i++) begin
      @(negedge clk);
      rd_idx = IW'(i);
      #1;
      if (i < K) chk("R2/R4 prev group", int'(rd_data), expect_elem(n, i, last));
      else if (i >= 2 * K) chk("R2/R5 next group", int'(rd_data), expect_elem(n, i, last));
      else chk("R2 centre group", int'(rd_data), expect_elem(n, i, last));
    end
  endtask

  task automatic check_out_of_range();
    for (int i = 3 * K; i < (1 << IW); i++) begin
      @(negedge clk);
      rd_idx = IW'(i);
      #1;
      chk("R1 index beyond regressor", int'(rd_data), 0);
    end
  endtask

  task automatic run_decisions();
    int  q[$];
    bit  hold_pend = 1'b0;
    bit  hold_pos  = 1'b0;
    int  directed[5] = '{0, -1, -512, 511, 1};
    int  v;
    for (int i = 0; i < 90; i++) begin
      @(negedge clk);
      if (hold_pend) begin
        chk("R10 held valid", int'(bit_valid), 1);
        chk("R10 held value", int'(bit_pos), int'(hold_pos));
        hold_pend = 1'b0;
      end
      bit_ready = (i >= 80) ? 1'b1 : (($urandom % 3) != 0);
      v = (i < 5) ? directed[i] : rand_val(1024);
      det_valid = (i < 5) ? 1'b1 : ((i < 75) && (($urandom % 4) != 0));
      det_data  = OW'(v);
      #1;
      chk("R10 det_ready", int'(det_ready), int'(!bit_valid || bit_ready));
      if (bit_valid && bit_ready) begin
        if (q.size() == 0) chk("R9 unexpected decision", 1, 0);
        else chk("R9 decision sign", int'(bit_pos), q.pop_front());
      end else if (bit_valid) begin
        hold_pend = 1'b1;
        hold_pos  = bit_pos;
      end
      if (det_valid && det_ready) q.push_back((v >= 0) ? 1 : 0);
    end
    det_valid = 1'b0;
    chk("R9 all decisions delivered", q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 win_valid", int'(win_valid), 0);
    chk("R11 wr_ready", int'(wr_ready), 1);
    chk("R11 bit_valid", int'(bit_valid), 0);
    chk("R11 det_ready", int'(det_ready), 1);

    // Frame A: ten symbols, extremes in symbol 0
    for (int s = 0; s < 10; s++)
      for (int u = 0; u < K; u++) sym_val[s][u] = rand_val(4096);
    sym_val[0][0] = -2048;
    sym_val[0][1] = 2047;
    sym_val[1][2] = 0;

    write_sym(0);
    chk("R3 not valid after one symbol", int'(win_valid), 0);
    write_user(1, 0);
    write_user(1, 1);
    chk("R3 not valid with partial next symbol", int'(win_valid), 0);
    write_user(1, 2);
    check_window(0, 1'b0);
    check_out_of_range();
    write_sym(2);
    chk("R6 ready low with two symbols ahead", int'(wr_ready), 0);
    check_window(0, 1'b0);
    pulse_done();
    chk("R6 ready back after release", int'(wr_ready), 1);
    check_window(1, 1'b0);
    begin
      int c = 1;
      for (int s = 3; s < 10; s++) begin
        write_sym(s);
        check_window(c, 1'b0);
        pulse_done();
        c++;
      end
      chk("R7 centre reached", c, 8);
    end
    check_window(8, 1'b0);
    pulse_end();
    chk("R5 writes closed", int'(wr_ready), 0);
    check_window(8, 1'b0);
    pulse_done();
    check_window(9, 1'b1);
    pulse_done();
    chk("R5 no window after last", int'(win_valid), 0);
    chk("R5 still closed", int'(wr_ready), 0);

    // Frame B: flush, ignored release, mid-frame flush
    pulse_flush();
    chk("R8 valid cleared", int'(win_valid), 0);
    chk("R8 ready restored", int'(wr_ready), 1);
    for (int s = 0; s < 3; s++)
      for (int u = 0; u < K; u++) sym_val[s][u] = rand_val(4096);
    write_sym(0);
    pulse_done();
    chk("R7 release ignored", int'(win_valid), 0);
    write_sym(1);
    check_window(0, 1'b0);
    write_sym(2);
    pulse_flush();
    chk("R8 mid-frame flush", int'(win_valid), 0);
    chk("R8 mid-frame ready", int'(wr_ready), 1);

    // Frame C: a single symbol, both outer groups zero
    for (int u = 0; u < K; u++) sym_val[0][u] = rand_val(4096);
    write_sym(0);
    chk("R3 single symbol not valid", int'(win_valid), 0);
    pulse_end();
    check_window(0, 1'b1);
    pulse_done();
    chk("R5 single window released", int'(win_valid), 0);
    pulse_flush();

    run_decisions();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule